// File: doc/BRIEF.md
# SMBus Word-Protocol Charger Register Slave

This block is a bus slave for a two-wire SMBus. It oversamples the clock and data lines with the system clock and recognises START, repeated START and STOP. It answers one fixed 7-bit address and serves Write-Word and Read-Word transactions against a small bank of 16-bit registers. Data goes low byte first. The block never drives the data line high. It only asserts a pull-low enable, and the pad turns that into an open-drain output.

Five writable control words are stored and driven out continuously: operating mode, charge current, charge voltage, alarm warning and input current. Each has a one-cycle write strobe. Four read-only words come in from outside and can be read over the bus: spec info, status, device ID and manufacturer ID. The reset input stands for a good supply. While it is low, every register holds its power-on value of zero and the bus is not served.

Top module: `smbw_slave`

## Requirements
- R1: While `pwr_ok` is low, and after it rises, all five control words and all strobes are zero, and `sda_pull_o` is 0.
- R2: The slave acknowledges only the address byte 0b0001001 followed by a write bit of 0. After any other first address byte, it leaves SDA released for every byte up to the next START or STOP, and no register changes.
- R3: A Write-Word (address, command, low byte D7..D0, high byte D15..D8, each acknowledged) stores {high,low} into the addressed word. The command-to-index map is: 0x12 mode = index 0, 0x14 charge current = 1, 0x15 charge voltage = 2, 0x16 alarm warning = 3, 0x3F input current = 4. Strobe bit `wr_stb_o[index]` pulses for exactly one cycle.
- R4: At most one strobe bit is high in any cycle. The control words change only in a cycle whose strobe is high.
- R5: A write to a read-only command (0x11, 0x13, 0xFE, 0xFF) or to an unlisted command has all four bytes acknowledged, and it changes no word and raises no strobe.
- R6: A Read-Word (address W, command, repeated START, address R) returns the low byte, then the high byte, MSB first. It returns `spec_info_i` for 0x11, `status_i` for 0x13, `dev_id_i` for 0xFE, `mfr_id_i` for 0xFF, and the stored word for each writable command.
- R7: A read of any command not listed in R6 returns 0xFFFF.
- R8: A STOP or a START before the high data byte has been acknowledged aborts the write, and the target word stays unchanged. A transfer that starts right after the abort is served normally.
- R9: `sda_pull_o` changes only while SCL is low.
- R10: Pulses on SCL or SDA shorter than three system clocks (after two-flop synchronization) do not disturb a transfer.
- R11: Dropping `pwr_ok` in mid-use clears every control word to zero. Bus traffic while `pwr_ok` is low gets no acknowledge and stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| pwr_ok | input | 1 | Supply good; low holds every register in its power-on state (asynchronous, active low) |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | Pull-low enable for the open-drain data driver |
| spec_info_i | input | 16 | Word returned for command 0x11 |
| status_i | input | 16 | Word returned for command 0x13 |
| dev_id_i | input | 16 | Word returned for command 0xFE |
| mfr_id_i | input | 16 | Word returned for command 0xFF |
| mode_o | output | 16 | Stored mode word (0x12) |
| chg_cur_o | output | 16 | Stored charge-current word (0x14) |
| chg_volt_o | output | 16 | Stored charge-voltage word (0x15) |
| alarm_o | output | 16 | Stored alarm-warning word (0x16) |
| in_cur_o | output | 16 | Stored input-current word (0x3F) |
| wr_stb_o | output | 5 | One-cycle update strobe per writable word, indexed as in R3 |

## Verification
The bench builds the block with its defaults: address 0x09, two synchronizer stages and a three-sample filter. The bus runs with a quarter SCL period of eight system clocks. That is longer than the six-cycle path through the filter, so every acknowledge and every transmitted bit can be sampled. It is also long enough that a two-cycle glitch on either line can be placed inside a bit. The read sweep covers the whole low command region, 0x00 to 0x1F, plus 0x3E, 0x3F, 0xFE and 0xFF. In that way, every defined code and its unlisted neighbours are checked against an arithmetic model of the register file.

// File: rtl/smbw_pkg.sv
package smbw_pkg;

    localparam int DATA_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int NUM_WR  = 5;

    // writable command codes
    localparam logic [7:0] CMD_MODE  = 8'h12;
    localparam logic [7:0] CMD_CUR   = 8'h14;
    localparam logic [7:0] CMD_VOLT  = 8'h15;
    localparam logic [7:0] CMD_ALARM = 8'h16;
    localparam logic [7:0] CMD_INCUR = 8'h3F;

    // read-only command codes
    localparam logic [7:0] CMD_SPEC  = 8'h11;
    localparam logic [7:0] CMD_STAT  = 8'h13;
    localparam logic [7:0] CMD_DEVID = 8'hFE;
    localparam logic [7:0] CMD_MFRID = 8'hFF;

    // command code of writable word by index
    function automatic logic [7:0] wr_cmd_of(input int idx);
        logic [7:0] c;
        case (idx)
            0:       c = CMD_MODE;
            1:       c = CMD_CUR;
            2:       c = CMD_VOLT;
            3:       c = CMD_ALARM;
            default: c = CMD_INCUR;
        endcase
        return c;
    endfunction

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_ADDR1,
        PH_CMD,
        PH_WLO,
        PH_WHI,
        PH_ADDR2,
        PH_TXLO,
        PH_TXHI,
        PH_SKIP
    } phase_e;

endpackage

// File: rtl/smbw_line_filter.sv
module smbw_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [FILT_LEN-1:0]    hist;
        logic                   level;
    } flt_t;

    flt_t flt_d, flt_q;

    always_comb begin
        flt_d      = flt_q;
        flt_d.sync = {flt_q.sync[SYNC_STAGES-2:0], line_i};
        flt_d.hist = {flt_q.hist[FILT_LEN-2:0], flt_q.sync[SYNC_STAGES-1]};
        // level follows only after FILT_LEN equal samples
        if (&flt_q.hist) begin
            flt_d.level = 1'b1;
        end else if (~|flt_q.hist) begin
            flt_d.level = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_q <= '1;
        end else begin
            flt_q <= flt_d;
        end
    end

    assign line_o = flt_q.level;

endmodule

// File: rtl/smbw_byte_fsm.sv
module smbw_byte_fsm
    import smbw_pkg::*;
#(
    parameter logic [6:0] ADDR7 = 7'h09
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [DATA_W-1:0] rd_word_i,
    output logic [7:0]        cmd_o,
    output logic              wr_en_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              pull_o
);

    localparam int CNT_W  = $clog2(BYTE_W + 2);
    localparam int BIT_IW = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0]  ACK_BIT  = CNT_W'(BYTE_W + 1);
    localparam logic [CNT_W-1:0]  ONE      = CNT_W'(1);
    localparam logic [BIT_IW-1:0] TOP_BIT  = BIT_IW'(BYTE_W - 1);

    typedef struct packed {
        phase_e              phase;
        logic [CNT_W-1:0]    cnt;
        logic [BYTE_W-1:0]   shreg;
        logic [7:0]          cmd;
        logic [BYTE_W-1:0]   lo;
        logic [BYTE_W-1:0]   hi;
        logic [DATA_W-1:0]   txw;
        logic                ack;
        logic                pull;
        logic                wr_en;
        logic                scl_p;
        logic                sda_p;
    } fsm_t;

    fsm_t st_d, st_q;

    logic scl_rise, scl_fall, start_seen, stop_seen, is_tx;
    logic [BIT_IW:0] tx_idx;

    assign scl_rise   = scl_i & ~st_q.scl_p;
    assign scl_fall   = ~scl_i & st_q.scl_p;
    assign start_seen = scl_i & st_q.scl_p & st_q.sda_p & ~sda_i;
    assign stop_seen  = scl_i & st_q.scl_p & ~st_q.sda_p & sda_i;
    assign is_tx      = (st_q.phase == PH_TXLO) || (st_q.phase == PH_TXHI);
    assign tx_idx     = {st_q.phase == PH_TXHI, TOP_BIT - st_q.cnt[BIT_IW-1:0]};

    always_comb begin
        st_d       = st_q;
        st_d.wr_en = 1'b0;
        st_d.scl_p = scl_i;
        st_d.sda_p = sda_i;
        if (stop_seen) begin
            st_d.phase = PH_IDLE;
            st_d.cnt   = '0;
            st_d.pull  = 1'b0;
        end else if (start_seen) begin
            st_d.cnt  = '0;
            st_d.pull = 1'b0;
            st_d.ack  = 1'b0;
            // a START just after the command byte is the read turnaround
            if (st_q.phase == PH_WLO && st_q.cnt <= ONE) begin
                st_d.phase = PH_ADDR2;
            end else begin
                st_d.phase = PH_ADDR1;
            end
        end else if (st_q.phase != PH_IDLE && st_q.phase != PH_SKIP) begin
            if (scl_rise) begin
                if (st_q.cnt < LAST_BIT) begin
                    st_d.shreg = {st_q.shreg[BYTE_W-2:0], sda_i};
                    st_d.cnt   = st_q.cnt + ONE;
                end else if (st_q.cnt == LAST_BIT) begin
                    st_d.cnt = ACK_BIT;
                    if (is_tx) begin
                        st_d.ack = ~sda_i;
                    end
                end
            end
            if (scl_fall) begin
                if (st_q.cnt == LAST_BIT) begin
                    if (is_tx) begin
                        st_d.pull = 1'b0;
                    end else begin
                        case (st_q.phase)
                            PH_ADDR1: st_d.ack = (st_q.shreg == {ADDR7, 1'b0});
                            PH_ADDR2: st_d.ack = (st_q.shreg == {ADDR7, 1'b1});
                            PH_CMD: begin
                                st_d.ack = 1'b1;
                                st_d.cmd = st_q.shreg;
                            end
                            PH_WLO: begin
                                st_d.ack = 1'b1;
                                st_d.lo  = st_q.shreg;
                            end
                            PH_WHI: begin
                                st_d.ack = 1'b1;
                                st_d.hi  = st_q.shreg;
                            end
                            default: st_d.ack = 1'b0;
                        endcase
                        st_d.pull = st_d.ack;
                    end
                end else if (st_q.cnt == ACK_BIT) begin
                    st_d.cnt  = '0;
                    st_d.pull = 1'b0;
                    if (!st_q.ack) begin
                        st_d.phase = PH_SKIP;
                    end else begin
                        case (st_q.phase)
                            PH_ADDR1: st_d.phase = PH_CMD;
                            PH_CMD:   st_d.phase = PH_WLO;
                            PH_WLO:   st_d.phase = PH_WHI;
                            PH_WHI: begin
                                st_d.wr_en = 1'b1;
                                st_d.phase = PH_SKIP;
                            end
                            PH_ADDR2: begin
                                st_d.phase = PH_TXLO;
                                st_d.txw   = rd_word_i;
                                st_d.pull  = ~rd_word_i[BYTE_W-1];
                            end
                            PH_TXLO: begin
                                st_d.phase = PH_TXHI;
                                st_d.pull  = ~st_q.txw[DATA_W-1];
                            end
                            default: st_d.phase = PH_SKIP;
                        endcase
                    end
                end else if (is_tx && st_q.cnt != '0) begin
                    st_d.pull = ~st_q.txw[tx_idx];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
            st_q.scl_p <= 1'b1;
            st_q.sda_p <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_o     = st_q.cmd;
    assign wr_en_o   = st_q.wr_en;
    assign wr_data_o = {st_q.hi, st_q.lo};
    assign pull_o    = st_q.pull;

endmodule

// File: rtl/smbw_reg_bank.sv
module smbw_reg_bank
    import smbw_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en_i,
    input  logic [7:0]                     cmd_i,
    input  logic [DATA_W-1:0]              wr_data_i,
    input  logic [DATA_W-1:0]              spec_info_i,
    input  logic [DATA_W-1:0]              status_i,
    input  logic [DATA_W-1:0]              dev_id_i,
    input  logic [DATA_W-1:0]              mfr_id_i,
    output logic [DATA_W-1:0]              rd_word_o,
    output logic [NUM_WR-1:0][DATA_W-1:0]  regs_o,
    output logic [NUM_WR-1:0]              stb_o
);

    typedef struct packed {
        logic [NUM_WR-1:0][DATA_W-1:0] regs;
        logic [NUM_WR-1:0]             stb;
    } bank_t;

    bank_t bk_d, bk_q;

    always_comb begin
        bk_d     = bk_q;
        bk_d.stb = '0;
        for (int i = 0; i < NUM_WR; i++) begin
            if (wr_en_i && cmd_i == wr_cmd_of(i)) begin
                bk_d.regs[i] = wr_data_i;
                bk_d.stb[i]  = 1'b1;
            end
        end
    end

    always_comb begin
        case (cmd_i)
            CMD_SPEC:  rd_word_o = spec_info_i;
            CMD_STAT:  rd_word_o = status_i;
            CMD_DEVID: rd_word_o = dev_id_i;
            CMD_MFRID: rd_word_o = mfr_id_i;
            default:   rd_word_o = '1;
        endcase
        for (int i = 0; i < NUM_WR; i++) begin
            if (cmd_i == wr_cmd_of(i)) begin
                rd_word_o = bk_q.regs[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bk_q <= '0;
        end else begin
            bk_q <= bk_d;
        end
    end

    assign regs_o = bk_q.regs;
    assign stb_o  = bk_q.stb;

endmodule

// File: rtl/smbw_slave.sv
module smbw_slave
    import smbw_pkg::*;
#(
    parameter logic [6:0] ADDR7       = 7'h09,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 3
) (
    input  logic              clk,
    input  logic              pwr_ok,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    input  logic [DATA_W-1:0] spec_info_i,
    input  logic [DATA_W-1:0] status_i,
    input  logic [DATA_W-1:0] dev_id_i,
    input  logic [DATA_W-1:0] mfr_id_i,
    output logic [DATA_W-1:0] mode_o,
    output logic [DATA_W-1:0] chg_cur_o,
    output logic [DATA_W-1:0] chg_volt_o,
    output logic [DATA_W-1:0] alarm_o,
    output logic [DATA_W-1:0] in_cur_o,
    output logic [NUM_WR-1:0] wr_stb_o
);

    localparam int NUM_LINES = 2;

    logic [NUM_LINES-1:0] raw_lines;
    logic [NUM_LINES-1:0] filt_lines;
    logic                 scl_f;
    logic                 sda_f;

    assign raw_lines = {scl_i, sda_i};

    for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_line
        smbw_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_flt (
            .clk   (clk),
            .rst_n (pwr_ok),
            .line_i(raw_lines[gi]),
            .line_o(filt_lines[gi])
        );
    end

    assign scl_f = filt_lines[1];
    assign sda_f = filt_lines[0];

    logic [7:0]                    cmd;
    logic                          wr_en;
    logic [DATA_W-1:0]             wr_data;
    logic [DATA_W-1:0]             rd_word;
    logic [NUM_WR-1:0][DATA_W-1:0] regs;

    smbw_byte_fsm #(
        .ADDR7(ADDR7)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (pwr_ok),
        .scl_i    (scl_f),
        .sda_i    (sda_f),
        .rd_word_i(rd_word),
        .cmd_o    (cmd),
        .wr_en_o  (wr_en),
        .wr_data_o(wr_data),
        .pull_o   (sda_pull_o)
    );

    smbw_reg_bank u_bank (
        .clk        (clk),
        .rst_n      (pwr_ok),
        .wr_en_i    (wr_en),
        .cmd_i      (cmd),
        .wr_data_i  (wr_data),
        .spec_info_i(spec_info_i),
        .status_i   (status_i),
        .dev_id_i   (dev_id_i),
        .mfr_id_i   (mfr_id_i),
        .rd_word_o  (rd_word),
        .regs_o     (regs),
        .stb_o      (wr_stb_o)
    );

    assign mode_o     = regs[0];
    assign chg_cur_o  = regs[1];
    assign chg_volt_o = regs[2];
    assign alarm_o    = regs[3];
    assign in_cur_o   = regs[4];

endmodule

// File: rtl/smbw_slave_chk.sv
module smbw_slave_chk #(
    parameter int NUM_WR = 5,
    parameter int DATA_W = 16
) (
    input logic                     clk,
    input logic                     pwr_ok,
    input logic                     scl_f,
    input logic                     sda_pull_o,
    input logic [NUM_WR-1:0]        wr_stb_o,
    input logic [NUM_WR*DATA_W-1:0] ctl_words
);

    // R9: data driver moves only in the low half of SCL
    a_r9_pull_moves_scl_low: assert property (@(posedge clk) disable iff (!pwr_ok)
        (sda_pull_o != $past(sda_pull_o)) |-> !$past(scl_f));

    // R4: never two strobes at once
    a_r4_single_strobe: assert property (@(posedge clk) disable iff (!pwr_ok)
        $onehot0(wr_stb_o));

    // R4: words hold unless a strobe is up
    a_r4_hold_without_strobe: assert property (@(posedge clk) disable iff (!pwr_ok)
        (wr_stb_o == '0) |-> $stable(ctl_words));

    // R3: commit lands after the acknowledge clock has fallen
    a_r3_commit_in_scl_low: assert property (@(posedge clk) disable iff (!pwr_ok)
        (wr_stb_o != '0) |-> !scl_f);

    // R3: strobe lasts one cycle
    a_r3_strobe_one_cycle: assert property (@(posedge clk) disable iff (!pwr_ok)
        (wr_stb_o != '0) |=> (wr_stb_o == '0));

endmodule

bind smbw_slave smbw_slave_chk u_chk (
    .clk       (clk),
    .pwr_ok    (pwr_ok),
    .scl_f     (scl_f),
    .sda_pull_o(sda_pull_o),
    .wr_stb_o  (wr_stb_o),
    .ctl_words ({mode_o, chg_cur_o, chg_volt_o, alarm_o, in_cur_o})
);

// File: tb/smbw_slave_tb_top.sv
module smbw_slave_tb_top;

    localparam int Q = 8;
    localparam logic [6:0] DEV = 7'h09;
    localparam logic [15:0] SPEC = 16'h1357, STAT = 16'h2468, DEVID = 16'hC0DE, MFRID = 16'h4D21;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic pwr_ok = 1'b0;
    logic scl_i = 1'b1;
    logic sda_m = 1'b1;
    logic sda_i;
    logic sda_pull_o;
    logic [15:0] mode_o, chg_cur_o, chg_volt_o, alarm_o, in_cur_o;
    logic [4:0] wr_stb_o;
    bit glitch_on = 1'b0;

    assign sda_i = sda_m & ~sda_pull_o;

    smbw_slave #(.ADDR7(DEV), .SYNC_STAGES(2), .FILT_LEN(3)) dut_i (
        .clk(clk), .pwr_ok(pwr_ok), .scl_i(scl_i), .sda_i(sda_i), .sda_pull_o(sda_pull_o),
        .spec_info_i(SPEC), .status_i(STAT), .dev_id_i(DEVID), .mfr_id_i(MFRID),
        .mode_o(mode_o), .chg_cur_o(chg_cur_o), .chg_volt_o(chg_volt_o),
        .alarm_o(alarm_o), .in_cur_o(in_cur_o), .wr_stb_o(wr_stb_o)
    );

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    int stb_cnt [5];
    int multi_stb = 0;
    int silent_change = 0;
    int pull_viol = 0;
    logic pull_prev = 1'b0;
    logic [79:0] words_prev = '0;
    logic [15:0] mdl [5];

    always @(posedge clk) begin
        if (pwr_ok) begin
            for (int i = 0; i < 5; i++) if (wr_stb_o[i]) stb_cnt[i]++;
            if ($countones(wr_stb_o) > 1) multi_stb++;
            if (wr_stb_o == 5'b0 && {mode_o, chg_cur_o, chg_volt_o, alarm_o, in_cur_o} != words_prev)
                silent_change++;
        end
        if (sda_pull_o !== pull_prev && scl_i) pull_viol++;
        pull_prev  <= sda_pull_o;
        words_prev <= {mode_o, chg_cur_o, chg_volt_o, alarm_o, in_cur_o};
    end

    function automatic logic [7:0] code_of(input int i);
        case (i)
            0: return 8'h12;
            1: return 8'h14;
            2: return 8'h15;
            3: return 8'h16;
            default: return 8'h3F;
        endcase
    endfunction

    function automatic logic [15:0] word_out(input int i);
        case (i)
            0: return mode_o;
            1: return chg_cur_o;
            2: return chg_volt_o;
            3: return alarm_o;
            default: return in_cur_o;
        endcase
    endfunction

    function automatic logic [15:0] exp_read(input logic [7:0] c);
        for (int i = 0; i < 5; i++) if (c == code_of(i)) return mdl[i];
        case (c)
            8'h11: return SPEC;
            8'h13: return STAT;
            8'hFE: return DEVID;
            8'hFF: return MFRID;
            default: return 16'hFFFF;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_words(input string req);
        for (int i = 0; i < 5; i++) chk(req, {16'h0, word_out(i)}, {16'h0, mdl[i]});
    endtask

    task automatic qwait();
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic bit_xfer(input logic b, output logic s);
        sda_m = b;
        if (glitch_on) begin
            repeat (3) @(posedge clk); #1 scl_i = 1'b1;
            repeat (2) @(posedge clk); #1 scl_i = 1'b0;
            repeat (Q - 5) @(posedge clk); #1;
        end else qwait();
        scl_i = 1'b1;
        if (glitch_on && b) begin
            repeat (3) @(posedge clk); #1 sda_m = 1'b0;
            repeat (2) @(posedge clk); #1 sda_m = 1'b1;
            repeat (Q - 5) @(posedge clk); #1;
        end else qwait();
        s = sda_i;
        qwait();
        scl_i = 1'b0;
        qwait();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack_n);
        logic s;
        for (int i = 7; i >= 0; i--) bit_xfer(v[i], s);
        bit_xfer(1'b1, ack_n);
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic mack_n);
        logic s;
        v = '0;
        for (int i = 0; i < 8; i++) begin
            bit_xfer(1'b1, s);
            v = {v[6:0], s};
        end
        bit_xfer(mack_n, s);
    endtask

    task automatic start_c();
        sda_m = 1'b0; qwait(); scl_i = 1'b0; qwait();
    endtask

    task automatic rstart_c();
        sda_m = 1'b1; qwait(); scl_i = 1'b1; qwait(); sda_m = 1'b0; qwait(); scl_i = 1'b0; qwait();
    endtask

    task automatic stop_c();
        sda_m = 1'b0; qwait(); scl_i = 1'b1; qwait(); sda_m = 1'b1; qwait(); qwait();
    endtask

    task automatic write_word(input logic [6:0] a, input logic [7:0] c, input logic [15:0] w,
                              output logic [3:0] acks);
        start_c();
        send_byte({a, 1'b0}, acks[3]);
        send_byte(c, acks[2]);
        send_byte(w[7:0], acks[1]);
        send_byte(w[15:8], acks[0]);
        stop_c();
    endtask

    task automatic read_word(input logic [7:0] c, output logic [15:0] w, output logic [2:0] acks);
        logic [7:0] lo, hi;
        start_c();
        send_byte({DEV, 1'b0}, acks[2]);
        send_byte(c, acks[1]);
        rstart_c();
        send_byte({DEV, 1'b1}, acks[0]);
        recv_byte(lo, 1'b0);
        recv_byte(hi, 1'b1);
        stop_c();
        w = {hi, lo};
    endtask

    task automatic stb_snapshot(output int snap [5]);
        for (int i = 0; i < 5; i++) snap[i] = stb_cnt[i];
    endtask

    task automatic chk_stb_delta(input string req, input int snap [5], input int hit);
        for (int i = 0; i < 5; i++) chk(req, stb_cnt[i] - snap[i], (i == hit) ? 1 : 0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        logic [3:0] a4;
        logic [2:0] a3;
        logic [15:0] rd;
        logic s, an;
        int snap [5];
        logic [15:0] v;
        logic [7:0] c;

        for (int i = 0; i < 5; i++) begin stb_cnt[i] = 0; mdl[i] = 16'h0; end

        // R1: power-on state
        repeat (10) @(posedge clk); #1;
        chk_words("R1 in reset");
        chk("R1 pull in reset", {31'h0, sda_pull_o}, 0);
        pwr_ok = 1'b1;
        repeat (10) @(posedge clk); #1;
        chk_words("R1 after reset");
        chk("R1 strobes", {27'h0, wr_stb_o}, 0);
        chk("R1 pull", {31'h0, sda_pull_o}, 0);

        // R3: each writable word with two value patterns
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 5; i++) begin
                v = (p == 0) ? (16'hA55A ^ (16'h1357 * (i + 1))) : ~(16'h0F01 << i);
                stb_snapshot(snap);
                write_word(DEV, code_of(i), v, a4);
                mdl[i] = v;
                chk("R3 acks", {28'h0, a4}, 0);
                chk_words("R3 word");
                chk_stb_delta("R3 strobe", snap, i);
            end
        end

        // R6 R7: read sweep
        for (int k = 0; k < 36; k++) begin
            case (k)
                32: c = 8'h3E;
                33: c = 8'h3F;
                34: c = 8'hFE;
                35: c = 8'hFF;
                default: c = k[7:0];
            endcase
            read_word(c, rd, a3);
            chk("R6 read acks", {29'h0, a3}, 0);
            if (exp_read(c) == 16'hFFFF && c != 8'hFF)
                chk("R7 unknown read", {16'h0, rd}, {16'h0, exp_read(c)});
            else
                chk("R6 read data", {16'h0, rd}, {16'h0, exp_read(c)});
        end

        // R5: writes to read-only and unknown commands
        for (int k = 0; k < 6; k++) begin
            case (k)
                0: c = 8'h11;
                1: c = 8'h13;
                2: c = 8'hFE;
                3: c = 8'hFF;
                4: c = 8'h00;
                default: c = 8'h40;
            endcase
            stb_snapshot(snap);
            write_word(DEV, c, 16'h6C39, a4);
            chk("R5 acks", {28'h0, a4}, 0);
            chk_words("R5 unchanged");
            chk_stb_delta("R5 no strobe", snap, -1);
        end
        read_word(8'h11, rd, a3);
        chk("R5 readonly kept", {16'h0, rd}, {16'h0, SPEC});

        // R2: foreign addresses
        for (int k = 0; k < 3; k++) begin
            stb_snapshot(snap);
            write_word((k == 0) ? 7'h0A : ((k == 1) ? 7'h48 : 7'h08), 8'h14, 16'h1111, a4);
            chk("R2 no ack", {28'h0, a4}, 4'b1111);
            chk_words("R2 unchanged");
            chk_stb_delta("R2 no strobe", snap, -1);
        end
        start_c();
        send_byte({DEV, 1'b1}, an);
        chk("R2 read bit first", {31'h0, an}, 1);
        stop_c();

        // R8: aborts
        stb_snapshot(snap);
        start_c();
        send_byte({DEV, 1'b0}, an); send_byte(8'h14, an); send_byte(8'h77, an);
        stop_c();
        chk_words("R8 stop after low byte");
        start_c();
        send_byte({DEV, 1'b0}, an); send_byte(8'h15, an); send_byte(8'h88, an);
        for (int i = 0; i < 4; i++) bit_xfer(i[0], s);
        stop_c();
        chk_words("R8 stop inside high byte");
        chk_stb_delta("R8 no strobe", snap, -1);
        start_c();
        send_byte({DEV, 1'b0}, an); send_byte(8'h14, an); send_byte(8'h99, an);
        rstart_c();
        send_byte({DEV, 1'b0}, a4[3]); send_byte(8'h15, a4[2]);
        send_byte(8'h34, a4[1]); send_byte(8'h12, a4[0]);
        stop_c();
        mdl[2] = 16'h1234;
        chk("R8 restart acks", {28'h0, a4}, 0);
        chk_words("R8 start abort then write");
        chk_stb_delta("R8 only second write", snap, 2);

        // R10: glitches on both lines during a write
        stb_snapshot(snap);
        glitch_on = 1'b1;
        write_word(DEV, 8'h16, 16'hB7E5, a4);
        glitch_on = 1'b0;
        mdl[3] = 16'hB7E5;
        chk("R10 acks", {28'h0, a4}, 0);
        chk_words("R10 glitch write");
        chk_stb_delta("R10 strobe", snap, 3);

        // R11: supply drop
        #1 pwr_ok = 1'b0;
        repeat (5) @(posedge clk); #1;
        for (int i = 0; i < 5; i++) mdl[i] = 16'h0;
        chk_words("R11 cleared");
        write_word(DEV, 8'h12, 16'h5555, a4);
        chk("R11 ignored while low", {28'h0, a4}, 4'b1111);
        pwr_ok = 1'b1;
        repeat (10) @(posedge clk); #1;
        chk_words("R11 nothing stored");
        write_word(DEV, 8'h12, 16'h0042, a4);
        mdl[0] = 16'h0042;
        chk("R11 acks after return", {28'h0, a4}, 0);
        chk_words("R11 write after return");

        // R4 R9: monitors
        chk("R4 multi strobe", multi_stb, 0);
        chk("R4 change without strobe", silent_change, 0);
        chk("R9 pull while scl high", pull_viol, 0);

        done = 1'b1;
        finish_run();
    end

endmodule